// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a bank of independent down-counting timer channels behind a single-cycle register bus. Software loads a reload value into a channel, enables it, and the channel counts down once per clock, restarting from the reload value each time it passes zero. Every pass through zero raises a sticky timeout flag. When the channel's interrupt enable is set, the flag drives that channel's own interrupt line.

A single module-disable bit freezes every counter at once. It comes out of reset set, so software must clear it before anything counts. Any channel other than channel 0 can be linked to the channel below it. A linked channel steps only when its lower neighbour passes zero, so a pair of channels acts as one 64-bit counter. A new reload value never disturbs a running count. Software aborts a period by turning the channel off and then on again.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the global register reads 0x2 (module disable set), every channel register reads 0 and all interrupt lines are low.
- R2: Address map. The global register is at 0x000 and bit 1 of it is module disable. Channel n starts at 0x100 + 0x10*n, with reload at +0x0, live count at +0x4 (read-only, writes ignored), control at +0x8 and status at +0xC. Any other address reads 0. Read data appears on `bus_rdata` one clock after the address.
- R3: An enabled, unfrozen, unlinked channel decrements on every clock. On the clock after it reads zero it reloads, so one period is reload+1 clocks.
- R4: Status bit 0 is set on the clock edge that ends a cycle in which an enabled, stepping channel reads zero. It stays set until software writes 1 to it. Writing 0 leaves it unchanged.
- R5: Control bit 1 is the interrupt enable. Output `irq[n]` is the status flag of channel n ANDed with that bit, and is registered alongside the flag.
- R6: Writing the reload register of a running channel leaves the current count unchanged. The new value is first used at the next reload.
- R7: Control bit 0 is the channel enable. A write that sets it while it is clear copies the reload value into the count. A write of 1 while it is already set does not reload.
- R8: While module disable is set, no counter changes except through an enable restart. Clearing the bit resumes counting from the held value without reloading.
- R9: Control bit 2 links channel n>0 to channel n-1. A linked channel steps once per zero pass of channel n-1, and its count holds at all other times. Setting the bit on channel 0 has no effect.
- R10: With a reload of 0xFFFFFFFF a channel runs as a free 32-bit down-counting time base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The main counting function is tried with a table of reload values and run lengths. The table covers a short run that ends before the first zero and a run that ends exactly one step past zero. It also has a run over several whole periods, a reload of zero, and an all-ones free-running load. Together these separate an off-by-one period, a missing reload and a wrong flag set time. Each entry also varies the interrupt-enable bit, so a line that follows the flag regardless of the enable shows up. Directed tests then update the reload of a running channel and repeat an enable write, to tell a harmless write apart from a restart. Further tests freeze and resume the module, and run a linked pair, where a linked channel that counts every clock gives a different count than one that steps on its neighbour's zero pass.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // selector for the four registers inside one channel slot
  typedef enum logic [1:0] {
    RG_RELOAD = 2'd0,
    RG_LIVE   = 2'd1,
    RG_CTL    = 2'd2,
    RG_STAT   = 2'd3
  } chan_reg_e;

  // control register fields, bit 0 upward: enable, interrupt enable, link
  typedef struct packed {
    logic link;
    logic irq_en;
    logic run_en;
  } chan_ctl_t;

  localparam int CTL_W       = 3;
  localparam int DIS_BIT     = 1;
  localparam int SLOT_LSB    = 4;
  localparam int SLOT_W      = 4;
  localparam int PAGE_LSB    = 8;
  localparam int CHAN_PAGE   = 1;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  output logic              glb_we,
  output logic              rd_glb,
  output logic              rd_chan,
  output logic [IDX_W-1:0]  rd_idx,
  output chan_reg_e         rd_reg,
  output logic [NUM_CH-1:0] ld_we,
  output logic [NUM_CH-1:0] ctl_we,
  output logic [NUM_CH-1:0] stat_we
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [SLOT_W-1:0] slot;
  logic [PAGE_W-1:0] page;
  logic              aligned;
  logic              glb_hit;
  logic              chan_hit;
  chan_reg_e         reg_sel;

  assign slot     = bus_addr[SLOT_LSB +: SLOT_W];
  assign page     = bus_addr[ADDR_W-1:PAGE_LSB];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign glb_hit  = (bus_addr == '0);
  assign chan_hit = (page == PAGE_W'(CHAN_PAGE)) && aligned && (int'(slot) < NUM_CH);
  assign reg_sel  = chan_reg_e'(bus_addr[3:2]);

  assign glb_we  = bus_we && glb_hit;
  assign rd_glb  = glb_hit;
  assign rd_chan = chan_hit;
  assign rd_idx  = bus_addr[SLOT_LSB +: IDX_W];
  assign rd_reg  = reg_sel;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_strobe
    logic mine;
    assign mine        = bus_we && chan_hit && (slot == SLOT_W'(ch));
    assign ld_we[ch]   = mine && (reg_sel == RG_RELOAD);
    assign ctl_we[ch]  = mine && (reg_sel == RG_CTL);
    assign stat_we[ch] = mine && (reg_sel == RG_STAT);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_we,
  input  logic              ctl_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_evt,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output chan_ctl_t         ctl_q,
  output logic              flag_q,
  output logic              irq_q,
  output logic              zero_evt
);
  chan_ctl_t         wctl;
  chan_ctl_t         ctl_d;
  logic [DATA_W-1:0] cnt_d;
  logic              flag_d;
  logic              step;
  logic              hit_zero;
  logic              restart;

  assign wctl = chan_ctl_t'(wdata[CTL_W-1:0]);

  // a linked channel steps only on the neighbour's zero pass;
  // channel 0 is fed a constant 1 so its link bit is inert
  assign step     = run && ctl_q.run_en && (!ctl_q.link || link_evt);
  assign hit_zero = step && (cnt_q == '0);
  assign restart  = ctl_we && wctl.run_en && !ctl_q.run_en;
  assign zero_evt = hit_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = load_q;
    else if (hit_zero) cnt_d = load_q;
    else if (step)     cnt_d = cnt_q - DATA_W'(1);

    ctl_d  = ctl_we ? wctl : ctl_q;
    flag_d = hit_zero || (flag_q && !(stat_we && wdata[0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ld_we) load_q <= wdata;
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
      irq_q  <= flag_d && ctl_d.irq_en;
    end
  end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_glb,
  input  logic                           rd_chan,
  input  logic [IDX_W-1:0]               rd_idx,
  input  chan_reg_e                      rd_reg,
  input  logic                           mod_dis,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  load_arr,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_arr,
  input  logic [NUM_CH-1:0][CTL_W-1:0]   ctl_arr,
  input  logic [NUM_CH-1:0]              flag_vec,
  output logic [DATA_W-1:0]              rdata
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    sel_d = '0;
    if (rd_glb) begin
      sel_d[DIS_BIT] = mod_dis;
    end else if (rd_chan) begin
      unique case (rd_reg)
        RG_RELOAD: sel_d = load_arr[rd_idx];
        RG_LIVE:   sel_d = cnt_arr[rd_idx];
        RG_CTL:    sel_d[CTL_W-1:0] = ctl_arr[rd_idx];
        RG_STAT:   sel_d[0] = flag_vec[rd_idx];
        default:   sel_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel_d;
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                          glb_we;
  logic                          rd_glb;
  logic                          rd_chan;
  logic [IDX_W-1:0]              rd_idx;
  chan_reg_e                     rd_reg;
  logic [NUM_CH-1:0]             ld_we;
  logic [NUM_CH-1:0]             ctl_we;
  logic [NUM_CH-1:0]             stat_we;
  logic                          mod_dis;
  logic [NUM_CH-1:0][DATA_W-1:0] load_arr;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_arr;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_arr;
  logic [NUM_CH-1:0]             flag_vec;
  logic [NUM_CH-1:0]             en_vec;
  logic [NUM_CH-1:0]             ie_vec;
  logic [NUM_CH-1:0]             link_vec;
  logic [NUM_CH-1:0]             zero_vec;

  tmr_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .glb_we   (glb_we),
    .rd_glb   (rd_glb),
    .rd_chan  (rd_chan),
    .rd_idx   (rd_idx),
    .rd_reg   (rd_reg),
    .ld_we    (ld_we),
    .ctl_we   (ctl_we),
    .stat_we  (stat_we)
  );

  // module disable comes out of reset set: counters frozen
  always_ff @(posedge clk) begin
    if (rst)         mod_dis <= 1'b1;
    else if (glb_we) mod_dis <= bus_wdata[DIS_BIT];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    chan_ctl_t ctl_w;
    logic      link_in;

    if (ch == 0) begin : g_head
      assign link_in = 1'b1;
    end else begin : g_tail
      assign link_in = zero_vec[ch-1];
    end

    tmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .run      (!mod_dis),
      .ld_we    (ld_we[ch]),
      .ctl_we   (ctl_we[ch]),
      .stat_we  (stat_we[ch]),
      .wdata    (bus_wdata),
      .link_evt (link_in),
      .load_q   (load_arr[ch]),
      .cnt_q    (cnt_arr[ch]),
      .ctl_q    (ctl_w),
      .flag_q   (flag_vec[ch]),
      .irq_q    (irq[ch]),
      .zero_evt (zero_vec[ch])
    );

    assign ctl_arr[ch]  = ctl_w;
    assign en_vec[ch]   = ctl_w.run_en;
    assign ie_vec[ch]   = ctl_w.irq_en;
    assign link_vec[ch] = ctl_w.link;
  end

  tmr_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_glb   (rd_glb),
    .rd_chan  (rd_chan),
    .rd_idx   (rd_idx),
    .rd_reg   (rd_reg),
    .mod_dis  (mod_dis),
    .load_arr (load_arr),
    .cnt_arr  (cnt_arr),
    .ctl_arr  (ctl_arr),
    .flag_vec (flag_vec),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_we,
  input logic                          mod_dis,
  input logic [NUM_CH-1:0]             en_vec,
  input logic [NUM_CH-1:0]             ie_vec,
  input logic [NUM_CH-1:0]             link_vec,
  input logic [NUM_CH-1:0]             flag_vec,
  input logic [NUM_CH-1:0]             irq,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_arr
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_irq_follow_r5: assert property (@(posedge clk) disable iff (rst)
      irq[ch] == (flag_vec[ch] && ie_vec[ch]));

    p_flag_w1c_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_vec[ch]) |-> $past(bus_we));

    p_flag_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_vec[ch]) |-> ($past(cnt_arr[ch]) == '0));

    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(mod_dis) && !$past(bus_we)) |-> $stable(cnt_arr[ch]));

    if (ch == 0) begin : g_head
      p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(mod_dis) && $past(en_vec[ch]) && !$past(bus_we) && ($past(cnt_arr[ch]) != '0))
        |-> (cnt_arr[ch] == $past(cnt_arr[ch]) - DATA_W'(1)));
    end else begin : g_tail
      p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(mod_dis) && $past(en_vec[ch]) && !$past(link_vec[ch]) && !$past(bus_we)
         && ($past(cnt_arr[ch]) != '0))
        |-> (cnt_arr[ch] == $past(cnt_arr[ch]) - DATA_W'(1)));

      p_link_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(link_vec[ch]) && ($past(cnt_arr[ch-1]) != '0) && !$past(bus_we))
        |-> $stable(cnt_arr[ch]));
    end
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .mod_dis  (mod_dis),
  .en_vec   (en_vec),
  .ie_vec   (ie_vec),
  .link_vec (link_vec),
  .flag_vec (flag_vec),
  .irq      (irq),
  .cnt_arr  (cnt_arr)
);

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  localparam int NCH = 4;
  localparam logic [11:0] GLB = 12'h000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tick_timer_bank uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // reload, run length (negedges between start and freeze), control
  localparam logic [95:0] VEC [6] = '{
    {32'd5,          32'd2,  32'd3},
    {32'd5,          32'd5,  32'd3},
    {32'd3,          32'd10, 32'd1},
    {32'd0,          32'd4,  32'd3},
    {32'hFFFF_FFFF,  32'd7,  32'd7},
    {32'd100,        32'd50, 32'd3}
  };

  function automatic logic [11:0] ra(input int ch, input int rg);
    return 12'(12'h100 + ch * 16 + rg * 4);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] ld, input int t);
    logic [31:0] v;
    v = ld;
    for (int j = 0; j < t; j++) v = (v == 32'd0) ? ld : v - 32'd1;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(GLB, d);          check("R1 global", d, 32'h2);
    rd(ra(3, 2), d);     check("R1 ctrl3", d, 32'h0);
    rd(ra(2, 1), d);     check("R1 count2", d, 32'h0);
    rd(ra(1, 0), d);     check("R1 reload1", d, 32'h0);
    check("R1 irq", {28'h0, irq}, 32'h0);

    // table: start at edge E, freeze at edge E+k+1, so k+1 steps
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ld, k, c, ev;
      logic [32:0] tt;
      logic ef;
      int ch;
      ch = i % NCH;
      {ld, k, c} = VEC[i];
      wr(GLB, 32'h2);
      wr(ra(ch, 2), 32'h0);
      wr(ra(ch, 3), 32'h1);
      wr(ra(ch, 0), ld);
      wr(ra(ch, 2), c);
      wr(GLB, 32'h0);
      repeat (int'(k)) @(negedge clk);
      wr(GLB, 32'h2);
      tt = 33'(k) + 33'd1;
      ev = model(ld, int'(k) + 1);
      ef = (tt > {1'b0, ld});
      rd(ra(ch, 1), d);
      if (ld == 32'hFFFF_FFFF) check(ch == 0 ? "R10 R9 count" : "R10 count", d, ev);
      else                     check("R3 count", d, ev);
      rd(ra(ch, 3), d);        check("R4 flag", d, {31'h0, ef});
      check("R5 irq", {31'h0, irq[ch]}, {31'h0, ef & c[1]});
    end

    // R6 reload write while running does not disturb count
    wr(GLB, 32'h2);
    wr(ra(2, 2), 32'h0);
    wr(ra(2, 3), 32'h1);
    wr(ra(2, 0), 32'd10);
    wr(ra(2, 2), 32'h1);
    wr(GLB, 32'h0);
    repeat (2) @(negedge clk);
    wr(ra(2, 0), 32'd3);
    repeat (2) @(negedge clk);
    wr(GLB, 32'h2);
    rd(ra(2, 1), d);     check("R6 count kept", d, 32'd4);
    wr(GLB, 32'h0);
    repeat (5) @(negedge clk);
    wr(GLB, 32'h2);
    rd(ra(2, 1), d);     check("R6 new reload used", d, 32'd2);

    // R7 enable restart
    wr(ra(2, 2), 32'h1);
    rd(ra(2, 1), d);     check("R7 no reload when on", d, 32'd2);
    wr(ra(2, 0), 32'd9);
    wr(ra(2, 2), 32'h0);
    wr(ra(2, 2), 32'h1);
    rd(ra(2, 1), d);     check("R7 restart", d, 32'd9);

    // R2 live count is read-only; unmapped reads zero
    wr(ra(2, 1), 32'd55);
    rd(ra(2, 1), d);     check("R2 count ro", d, 32'd9);
    rd(12'h0F0, d);      check("R2 unmapped", d, 32'h0);

    // R8 freeze and resume
    repeat (10) @(negedge clk);
    rd(ra(2, 1), d);     check("R8 frozen", d, 32'd9);
    wr(GLB, 32'h0);
    @(negedge clk);
    wr(GLB, 32'h2);
    rd(ra(2, 1), d);     check("R8 resume", d, 32'd7);

    // R4 write-one-to-clear
    rd(ra(2, 3), d);     check("R4 flag set", d, 32'h1);
    wr(ra(2, 3), 32'h0);
    rd(ra(2, 3), d);     check("R4 write0 ignored", d, 32'h1);
    wr(ra(2, 3), 32'h1);
    rd(ra(2, 3), d);     check("R4 write1 clears", d, 32'h0);

    // R9 linked pair: ch0 reload 2 (link bit set, inert), ch1 reload 5 linked
    wr(ra(0, 2), 32'h0);
    wr(ra(0, 0), 32'd2);
    wr(ra(1, 2), 32'h0);
    wr(ra(1, 3), 32'h1);
    wr(ra(1, 0), 32'd5);
    wr(ra(0, 2), 32'h5);
    wr(ra(1, 2), 32'h5);
    wr(GLB, 32'h0);
    repeat (6) @(negedge clk);
    wr(GLB, 32'h2);
    rd(ra(0, 1), d);     check("R9 ch0 ignores link", d, 32'd1);
    rd(ra(1, 1), d);     check("R9 ch1 linked", d, 32'd3);
    rd(ra(1, 3), d);     check("R9 ch1 flag", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule